// File: doc/BRIEF.md
# Multi-channel oversampled line clock recovery

This block takes a bank of slow line clocks, each with its own data bit. The clocks are not related to each other. It brings all of them into one fast system clock domain. No line clock drives a flip-flop clock pin. Each line clock is treated as an ordinary data input. The system clock samples it through a synchronizer chain, and the result is compared with its value one cycle earlier. A transition of the selected polarity becomes a single-cycle enable for that channel. The enable then loads the channel's data bit into an output register, and a valid strobe goes out beside it.

The data bits pass through a register delay line one stage longer than the clock synchronizer. The extra stage matches the edge register. As a result, the data value captured is the one present on the line when the clock transition was first sampled, which is a window where line data is stable. The system clock should run at eight or more times the line clock rate, so that every level of the line clock lasts at least two system cycles. Channel count, synchronizer depth and edge polarity are parameters. With the defaults (16 channels, two synchronizer stages, rising edge), the output strobe comes four system cycles after the sampling edge that first sees the new clock level.

Top module: `line_clk_recover`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `rx_vld` and `rx_dat` are all zero.
- R2: A low-to-high change on `line_clk[i]` that is first sampled at system edge P makes `rx_vld[i]` high for exactly one cycle, namely the cycle after edge P+3.
- R3: When `rx_vld[i]` is high, `rx_dat[i]` equals the value `line_dat[i]` had at system edge P, the edge that first sampled the new high clock level.
- R4: A high-to-low change on `line_clk[i]`, or a level held steady, produces no pulse on `rx_vld[i]`.
- R5: `rx_dat[i]` changes only in a cycle where `rx_vld[i]` is high. Changes on `line_dat[i]` with no rising clock edge leave it unchanged.
- R6: Channels are independent. A rising edge on one set of channels pulses exactly those bits of `rx_vld`, and each of those bits carries its own channel's data.
- R7: No `rx_vld` bit is high in the first three cycles after reset release. A line clock already high at release counts as a rising edge and pulses in the fourth cycle.
- R8: Rising edges on one channel that are eight or more system cycles apart each produce their own separate strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; all registers use its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| line_clk | input | NUM_CH | Asynchronous line clocks, sampled as data |
| line_dat | input | NUM_CH | Line data bits, one per channel |
| rx_dat | output | NUM_CH | Captured data bit per channel |
| rx_vld | output | NUM_CH | One-cycle strobe per channel marking new `rx_dat` |

## Verification
The bound checker checks four properties on every cycle:
- a strobe never lasts two cycles,
- every strobe follows a matching transition of the synchronized clock,
- output data moves only together with its strobe,
- no strobe appears in the quiet window after reset.

The bench's directed scenarios cover the rest:
- the exact cycle of each strobe,
- which data value is captured,
- channel independence under mixed masks,
- back-to-back edges,
- a clock that is already high when reset is released.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;

   localparam int MIN_SYNC_STAGES = 2;
   localparam int MAX_SYNC_STAGES = 4;

   function automatic int data_delay(input int sync_stages);
      return sync_stages + 1;
   endfunction

endpackage

// File: rtl/lcr_delay_line.sv
module lcr_delay_line #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stg_q [STAGES];

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("lcr_delay_line: STAGES must be at least 1");
      end
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) stg_q[0] <= '0;
               else        stg_q[0] <= din;
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (!rst_n) stg_q[k] <= '0;
               else        stg_q[k] <= stg_q[k-1];
            end
         end
      end
   endgenerate

   assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/lcr_edge_det.sv
module lcr_edge_det
   import lcr_pkg::*;
#(
   parameter int         WIDTH = 16,
   parameter edge_kind_e EDGE  = EDGE_RISE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] hit
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] hit_d;
   logic [WIDTH-1:0] hit_q;

   generate
      if (EDGE == EDGE_RISE) begin : g_rise
         assign hit_d = level & ~prev_q;
      end else begin : g_fall
         assign hit_d = ~level & prev_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         hit_q  <= '0;
      end else begin
         prev_q <= level;
         hit_q  <= hit_d;
      end
   end

   assign hit = hit_q;

endmodule

// File: rtl/lcr_capture.sv
module lcr_capture #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [WIDTH-1:0] strobe
);

   logic [WIDTH-1:0] dat_q;
   logic [WIDTH-1:0] stb_q;

   generate
      for (genvar c = 0; c < WIDTH; c++) begin : g_ch
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dat_q[c] <= 1'b0;
               stb_q[c] <= 1'b0;
            end else begin
               stb_q[c] <= load[c];
               if (load[c]) dat_q[c] <= din[c];
            end
         end
      end
   endgenerate

   assign dout   = dat_q;
   assign strobe = stb_q;

endmodule

// File: rtl/line_clk_recover.sv
module line_clk_recover
   import lcr_pkg::*;
#(
   parameter int         NUM_CH      = 16,
   parameter int         SYNC_STAGES = 2,
   parameter edge_kind_e EDGE        = EDGE_RISE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] line_clk,
   input  logic [NUM_CH-1:0] line_dat,
   output logic [NUM_CH-1:0] rx_dat,
   output logic [NUM_CH-1:0] rx_vld
);

   localparam int DAT_STAGES = data_delay(SYNC_STAGES);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("line_clk_recover: NUM_CH must be positive");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES || SYNC_STAGES > MAX_SYNC_STAGES) begin : g_bad_sync
         $error("line_clk_recover: SYNC_STAGES out of range");
      end
   endgenerate

   logic [NUM_CH-1:0] sync_clk;
   logic [NUM_CH-1:0] dly_dat;
   logic [NUM_CH-1:0] edge_en;

   lcr_delay_line #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_clk_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_clk),
      .dout (sync_clk)
   );

   lcr_delay_line #(.WIDTH(NUM_CH), .STAGES(DAT_STAGES)) u_dat_align (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_dat),
      .dout (dly_dat)
   );

   lcr_edge_det #(.WIDTH(NUM_CH), .EDGE(EDGE)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .level(sync_clk),
      .hit  (edge_en)
   );

   lcr_capture #(.WIDTH(NUM_CH)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (edge_en),
      .din   (dly_dat),
      .dout  (rx_dat),
      .strobe(rx_vld)
   );

endmodule

// File: rtl/lcr_checker.sv
module lcr_checker #(
   parameter int NUM_CH      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit FALL        = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] rx_dat,
   input logic [NUM_CH-1:0] rx_vld,
   input logic [NUM_CH-1:0] sync_clk
);

   localparam int QUIET = SYNC_STAGES + 2;

   logic [7:0] since_rst;

   always_ff @(posedge clk) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != 8'hff) since_rst <= since_rst + 8'd1;
   end

   // R2: a strobe lasts one cycle only
   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_vld != '0) |=> ((rx_vld & $past(rx_vld)) == '0));

   // R4: a strobe needs a transition of the selected polarity on the synchronized clock
   p_vld_from_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_vld != '0) |->
         ((rx_vld & ~(($past(sync_clk, 2) ^ $past(sync_clk, 3)) &
                      (FALL ? ~$past(sync_clk, 2) : $past(sync_clk, 2)))) == '0));

   // R5: output data changes only with its strobe
   p_dat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_dat ^ $past(rx_dat)) & ~rx_vld) == '0);

   // R7: quiet window after reset release
   p_quiet_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < QUIET) |-> (rx_vld == '0));

endmodule

bind line_clk_recover lcr_checker #(
   .NUM_CH     (NUM_CH),
   .SYNC_STAGES(SYNC_STAGES),
   .FALL       (EDGE == lcr_pkg::EDGE_FALL)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .rx_dat  (rx_dat),
   .rx_vld  (rx_vld),
   .sync_clk(sync_clk)
);

// File: tb/line_clk_recover_tb.sv
module line_clk_recover_tb_top;

   localparam int  CLK_PERIOD = 10;
   localparam int  NCH        = 16;
   localparam int  LAT        = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] line_clk = '0;
   logic [NCH-1:0] line_dat = '0;
   logic [NCH-1:0] rx_dat;
   logic [NCH-1:0] rx_vld;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   line_clk_recover dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_clk(line_clk),
      .line_dat(line_dat),
      .rx_dat  (rx_dat),
      .rx_vld  (rx_vld)
   );

   task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [NCH-1:0] clk_lvl);
      @(negedge clk);
      rst_n    = 1'b0;
      line_clk = clk_lvl;
      line_dat = '0;
      repeat (5) @(negedge clk);
   endtask

   // drive a clock change now; strobe expected after LAT negedges when rising
   task automatic edge_and_check(input string req, input logic [NCH-1:0] new_clk,
                                 input logic [NCH-1:0] new_dat,
                                 input logic [NCH-1:0] exp_vld,
                                 input logic [NCH-1:0] exp_dat);
      line_clk = new_clk;
      line_dat = new_dat;
      repeat (LAT-1) @(negedge clk);
      check(req, rx_vld, '0);
      @(negedge clk);
      check(req, rx_vld, exp_vld);
      check(req, rx_dat, exp_dat);
      @(negedge clk);
      check(req, rx_vld, '0);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset_r1();
      do_reset('0);
      check("R1 vld in reset", rx_vld, '0);
      check("R1 dat in reset", rx_dat, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 vld after release", rx_vld, '0);
      check("R1 dat after release", rx_dat, '0);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_single_edge_r2_r3();
      edge_and_check("R2/R3 rise data one", 16'h0001, 16'h0001, 16'h0001, 16'h0001);
      line_clk = '0;
      repeat (6) @(negedge clk);
      edge_and_check("R2/R3 rise data zero", 16'h0001, 16'h0000, 16'h0001, 16'h0000);
      line_clk = '0;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_no_edge_r4_r5();
      line_clk = 16'hffff;
      line_dat = 16'h00ff;
      repeat (LAT+1) @(negedge clk);
      line_dat = 16'h5a5a;
      repeat (6) @(negedge clk);
      check("R5 dat holds", rx_dat, 16'h00ff);
      line_clk = '0;
      line_dat = 16'ha5a5;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         check("R4 no strobe on fall", rx_vld, '0);
      end
      check("R5 dat holds after fall", rx_dat, 16'h00ff);
   endtask

   task automatic t_independent_r6();
      line_dat = '0;
      edge_and_check("R6 mixed mask", 16'h8421, 16'h8001, 16'h8421, 16'h80ff & 16'h80ff & 16'h8001 | (16'h00ff & ~16'h8421));
      line_clk = '0;
      repeat (6) @(negedge clk);
      edge_and_check("R6 other mask", 16'h7bde, 16'hffff, 16'h7bde, 16'hffff & 16'h7bde | (16'h8001 & ~16'h7bde));
      line_clk = '0;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_repeat_r8();
      logic [NCH-1:0] prev;
      prev = rx_dat;
      for (int n = 0; n < 3; n++) begin
         logic d;
         d = n[0];
         line_clk[3] = 1'b1;
         line_dat[3] = d;
         repeat (LAT) @(negedge clk);
         check("R8 repeated strobe", rx_vld, 16'h0008);
         check("R8 repeated data", rx_dat, (prev & ~16'h0008) | (NCH'(d) << 3));
         line_clk[3] = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic t_high_at_release_r7();
      do_reset(16'h0f0f);
      rst_n = 1'b1;
      for (int k = 0; k < LAT-1; k++) begin
         @(negedge clk);
         check("R7 quiet window", rx_vld, '0);
      end
      @(negedge clk);
      check("R7 first strobe", rx_vld, 16'h0f0f);
      @(negedge clk);
      check("R7 strobe ends", rx_vld, '0);
   endtask

   initial begin
      t_reset_r1();
      t_single_edge_r2_r3();
      t_no_edge_r4_r5();
      t_independent_r6();
      t_repeat_r8();
      t_high_at_release_r7();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule